// File: doc/BRIEF.md
# Trigger-Started Synchronizable Up-Counter

This block is an up-counting timer that can be started by a trigger as well as by software, and that can hand its own start on to other copies of itself. A small write port holds the configuration: which trigger source to watch, whether a trigger should start the counter, what to drive on the outgoing trigger line, a prescaler, and a synchronisation bit. Two trigger sources are offered: the outgoing trigger line of a neighbouring timer, and an external channel input. Each selected rising edge sets a sticky flag. In event mode, that edge also switches the counter on, and it stays on until software switches it off.

Timers are chained by wiring one timer's trigger output to the next timer's neighbour input. The upstream timer's master mode is set to drive its enable onto the trigger line. Its synchronisation bit holds back its own counting by the latency of that chain. A downstream timer in event mode then begins counting on the same clock edge as the upstream one, and the two counters stay in step.

Top module: `sync_timer`

## Requirements
- R1: After a synchronous reset the count is 0, the enable, the flag and the trigger output are 0, the prescaler is 0 and all configuration fields are 0.
- R2: Control register (address 0) bits [3:1] hold the master mode. With value 3'b001, the trigger output shows the enable bit one clock later. With any other value it is driven low one clock later.
- R3: Control bits [6:4] hold the trigger select. Value 3'b010 makes a rising edge on the neighbour trigger input a trigger event.
- R4: Trigger select value 3'b100 makes a rising edge on the external channel input a trigger event. Any select value other than 3'b010 and 3'b100 produces no events from either input.
- R5: Control bits [9:7] hold the slave mode. With value 3'b110 (event mode), a trigger event sets the enable at the next clock edge. Later trigger events leave it set.
- R6: With any slave mode other than 3'b110, trigger events leave the enable unchanged.
- R7: Every trigger event sets the flag, whatever the slave mode. The flag stays set until a write to address 2 with bit 0 low. A write with bit 0 high leaves it set, and an event in the same cycle as a clear wins.
- R8: Address 1 holds the prescaler value P. While counting, the count rises by one every P+1 clocks. The first rise comes P+1 clocks after counting begins, because the divider restarts whenever counting is off.
- R9: A write to address 0 sets the enable from bit 0 with no trigger needed. When the enable is cleared, the count stops changing from the next clock onward and keeps its value.
- R10: With control bit 10 (sync) set, counting begins only after the enable has been set for SYNC_DLY+1 consecutive cycles (3 cycles by default). Clearing the enable stops counting at once.
- R11: A master in master mode 3'b001 with sync set, started by the channel input, and a slave in event mode with select 3'b010 fed from the master's trigger output, with equal prescalers, show equal counts on every clock.
- R12: The count wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 prescaler, 2 flag |
| wr_data | input | DATA_W | Write data |
| nbr_trig_i | input | 1 | Trigger line from a neighbouring timer |
| ch0_i | input | 1 | External channel input |
| trig_o | output | 1 | Trigger line towards other timers |
| cen_o | output | 1 | Counter enable bit as software sees it |
| flag_o | output | 1 | Sticky trigger flag |
| count_o | output | CNT_W | Counter value |

## Verification
The hardest situation to reach is two timers that start through the chained trigger path and then count in lockstep. The master's sync holdoff and the slave's edge detection both have to be timed right, and a one-cycle slip shows only as a constant offset between two counts. The bench builds a master and a slave, clears both counters with a reset, and sets a nonzero prescaler so the dividers must also line up. It then starts the pair with one pulse on the master's channel input and compares the two counts cycle by cycle. Reaching the wrap needs about 65,000 clocks of free counting at prescaler 0, which the bench waits out before checking for zero.

// File: rtl/sync_tmr_pkg.sv
package sync_tmr_pkg;

    // Master mode codes (what drives the outgoing trigger)
    localparam logic [2:0] MM_QUIET    = 3'b000;
    localparam logic [2:0] MM_CEN      = 3'b001;

    // Trigger source codes
    localparam logic [2:0] TS_NEIGHBOUR = 3'b010;
    localparam logic [2:0] TS_CH0       = 3'b100;

    // Slave mode codes
    localparam logic [2:0] SM_NONE     = 3'b000;
    localparam logic [2:0] SM_EVENT    = 3'b110;

    typedef enum logic [1:0] {
        REG_CTRL     = 2'd0,
        REG_PRESCALE = 2'd1,
        REG_FLAG     = 2'd2,
        REG_SPARE    = 2'd3
    } reg_addr_e;

    // Control word above the enable bit (bit 0)
    typedef struct packed {
        logic       sync;
        logic [2:0] smode;
        logic [2:0] tsel;
        logic [2:0] mmode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        return cfg_t'(raw);
    endfunction

    function automatic logic starts_on_event(input cfg_t c);
        return c.smode == SM_EVENT;
    endfunction

    function automatic logic drives_enable(input cfg_t c);
        return c.mmode == MM_CEN;
    endfunction

endpackage

// File: rtl/sync_tmr_trig_in.sv
module sync_tmr_trig_in
    import sync_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] tsel,
    input  logic       nbr_i,
    input  logic       ch0_i,
    output logic       evt
);
    logic nbr_q;
    logic ch0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nbr_q <= 1'b0;
            ch0_q <= 1'b0;
        end else begin
            nbr_q <= nbr_i;
            ch0_q <= ch0_i;
        end
    end

    always_comb begin
        case (tsel)
            TS_NEIGHBOUR: evt = nbr_i & ~nbr_q;
            TS_CH0:       evt = ch0_i & ~ch0_q;
            default:      evt = 1'b0;
        endcase
    end

    AST_EVT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst) evt |-> (tsel == TS_NEIGHBOUR || tsel == TS_CH0)) else $error("event without a valid source"); // R4

endmodule

// File: rtl/sync_tmr_start.sv
module sync_tmr_start #(
    parameter int SYNC_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctrl,
    input  logic wr_cen,
    input  logic trig_evt,
    input  logic event_mode,
    input  logic sync_en,
    output logic cen_q,
    output logic cnt_en
);
    logic cen_d;

    always_comb begin
        cen_d = wr_ctrl ? wr_cen : cen_q;
        if (trig_evt && event_mode) begin
            cen_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cen_q <= 1'b0;
        end else begin
            cen_q <= cen_d;
        end
    end

    generate
        if (SYNC_DLY > 0) begin : g_hold
            // hist_q[k] is high when the enable has been high for k+1 past cycles in a row
            logic [SYNC_DLY-1:0] hist_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else begin
                    hist_q[0] <= cen_q;
                    for (int k = 1; k < SYNC_DLY; k++) begin
                        hist_q[k] <= hist_q[k-1] & cen_q;
                    end
                end
            end

            assign cnt_en = cen_q & (~sync_en | hist_q[SYNC_DLY-1]);

            AST_SYNC_HOLDOFF: assert property (@(posedge clk) disable iff (rst) (sync_en && $rose(cen_q)) |-> !cnt_en) else $error("sync start not held off"); // R10
        end else begin : g_direct
            assign cnt_en = cen_q;
        end
    endgenerate

    AST_EVENT_STARTS: assert property (@(posedge clk) disable iff (rst) (trig_evt && event_mode) |=> cen_q) else $error("event mode did not start"); // R5
    AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (rst) !cen_q |-> !cnt_en) else $error("counting while disabled"); // R9

endmodule

// File: rtl/sync_tmr_count.sv
module sync_tmr_count #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] count_q
);
    logic [PSC_W-1:0] div_q;
    logic             tick;

    assign tick = cnt_en && (div_q == psc);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            count_q <= '0;
        end else begin
            if (!cnt_en || tick) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
            if (tick) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(count_q)) else $error("count moved while idle"); // R9
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst) cnt_en |=> (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1))) else $error("count jumped"); // R8

endmodule

// File: rtl/sync_timer.sv
module sync_timer
    import sync_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 16,
    parameter int DATA_W   = 16,   // must cover PSC_W and CFG_W+1
    parameter int SYNC_DLY = 2     // matches the downstream edge stage plus the trigger register
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nbr_trig_i,
    input  logic              ch0_i,
    output logic              trig_o,
    output logic              cen_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  count_o
);
    reg_addr_e        addr;
    logic             wr_ctrl;
    logic             wr_psc;
    logic             wr_flag_clr;
    cfg_t             cfg_q;
    logic [PSC_W-1:0] psc_q;
    logic             trig_evt;
    logic             cen_q;
    logic             cnt_en;

    assign addr        = reg_addr_e'(wr_addr);
    assign wr_ctrl     = wr_en && (addr == REG_CTRL);
    assign wr_psc      = wr_en && (addr == REG_PRESCALE);
    assign wr_flag_clr = wr_en && (addr == REG_FLAG) && !wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            psc_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q <= decode_cfg(wr_data[CFG_W:1]);
            end
            if (wr_psc) begin
                psc_q <= wr_data[PSC_W-1:0];
            end
        end
    end

    sync_tmr_trig_in u_trig_in (
        .clk   (clk),
        .rst   (rst),
        .tsel  (cfg_q.tsel),
        .nbr_i (nbr_trig_i),
        .ch0_i (ch0_i),
        .evt   (trig_evt)
    );

    sync_tmr_start #(
        .SYNC_DLY (SYNC_DLY)
    ) u_start (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_cen     (wr_data[0]),
        .trig_evt   (trig_evt),
        .event_mode (starts_on_event(cfg_q)),
        .sync_en    (cfg_q.sync),
        .cen_q      (cen_q),
        .cnt_en     (cnt_en)
    );

    sync_tmr_count #(
        .CNT_W (CNT_W),
        .PSC_W (PSC_W)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .psc     (psc_q),
        .count_q (count_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            trig_o <= 1'b0;
        end else begin
            if (trig_evt) begin
                flag_o <= 1'b1;
            end else if (wr_flag_clr) begin
                flag_o <= 1'b0;
            end
            trig_o <= drives_enable(cfg_q) ? cen_q : 1'b0;
        end
    end

    assign cen_o = cen_q;

    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (rst) trig_evt |=> flag_o) else $error("flag missed an event"); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag_o && !wr_flag_clr) |=> flag_o) else $error("flag dropped by itself"); // R7
    AST_NO_START_OUTSIDE_EVENT: assert property (@(posedge clk) disable iff (rst) (!cen_q && !wr_ctrl && !starts_on_event(cfg_q)) |=> !cen_q) else $error("enable set without cause"); // R6

endmodule

// File: tb/sync_timer_bench.sv
`timescale 1ns/1ps
module sync_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_en = 2'b00;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ch_m = 1'b0;
    logic        trg [2];
    logic        cen [2];
    logic        flg [2];
    logic [15:0] cnt [2];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sync_timer u_sync_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_addr(wr_addr), .wr_data(wr_data),
        .nbr_trig_i(1'b0), .ch0_i(ch_m),
        .trig_o(trg[0]), .cen_o(cen[0]), .flag_o(flg[0]), .count_o(cnt[0])
    );

    sync_timer u_sync_timer_slv (
        .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_addr(wr_addr), .wr_data(wr_data),
        .nbr_trig_i(trg[0]), .ch0_i(1'b0),
        .trig_o(trg[1]), .cen_o(cen[1]), .flag_o(flg[1]), .count_o(cnt[1])
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt[2], m_div[2], m_cen[2], m_age[2], m_flg[2], m_trg[2];
    int m_pn[2], m_pc[2], m_psc[2], m_mm[2], m_ts[2], m_sm[2], m_sy[2];

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_div[i] = 0; m_cen[i] = 0; m_age[i] = 0; m_flg[i] = 0;
            m_trg[i] = 0; m_pn[i] = 0; m_pc[i] = 0; m_psc[i] = 0; m_mm[i] = 0;
            m_ts[i] = 0; m_sm[i] = 0; m_sy[i] = 0;
        end
    endtask

    task automatic model_step();
        int old_trg[2];
        int d;
        old_trg = m_trg;
        d = int'(wr_data);
        for (int i = 0; i < 2; i++) begin
            int nb, ch, evt, run, ncen, wc, wp, wf;
            nb  = (i == 1) ? old_trg[0] : 0;
            ch  = (i == 0) ? int'(ch_m) : 0;
            evt = ((m_ts[i] == 2) && nb == 1 && m_pn[i] == 0) ||
                  ((m_ts[i] == 4) && ch == 1 && m_pc[i] == 0);
            run = (m_cen[i] == 1) && (m_sy[i] == 0 || m_age[i] >= 3);
            wc  = wr_en[i] && wr_addr == 2'd0;
            wp  = wr_en[i] && wr_addr == 2'd1;
            wf  = wr_en[i] && wr_addr == 2'd2;
            if (run) begin
                if (m_div[i] == m_psc[i]) begin
                    m_div[i] = 0;
                    m_cnt[i] = (m_cnt[i] + 1) % 65536;
                end else begin
                    m_div[i] = m_div[i] + 1;
                end
            end else begin
                m_div[i] = 0;
            end
            ncen = wc ? (d & 1) : m_cen[i];
            if (evt && m_sm[i] == 6) ncen = 1;
            if (evt) m_flg[i] = 1;
            else if (wf && (d & 1) == 0) m_flg[i] = 0;
            m_trg[i] = (m_mm[i] == 1) ? m_cen[i] : 0;
            m_age[i] = (ncen == 0) ? 0 : ((m_cen[i] == 1) ? ((m_age[i] < 9) ? m_age[i] + 1 : 9) : 1);
            m_cen[i] = ncen;
            if (wc) begin
                m_mm[i] = (d >> 1) & 7;
                m_ts[i] = (d >> 4) & 7;
                m_sm[i] = (d >> 7) & 7;
                m_sy[i] = (d >> 10) & 1;
            end
            if (wp) m_psc[i] = d;
            m_pn[i] = nb;
            m_pc[i] = ch;
        end
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
        #1;
        for (int i = 0; i < 2; i++) begin
            chk("R8 model count", int'(cnt[i]), m_cnt[i]);
            chk("R5 model enable", int'(cen[i]), m_cen[i]);
            chk("R7 model flag", int'(flg[i]), m_flg[i]);
            chk("R2 model trigger", int'(trg[i]), m_trg[i]);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] ctl(input int en, input int mm, input int ts, input int sm, input int sy);
        return 16'((sy << 10) | (sm << 7) | (ts << 4) | (mm << 1) | en);
    endfunction

    task automatic wr(input int t, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en[t] = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_en[t] = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        ch_m = 1'b1;
        @(negedge clk);
        ch_m = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog R1-wide run: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(cnt[0]), 0);
        chk("R1 enable", int'(cen[0]), 0);
        chk("R1 flag", int'(flg[0]), 0);
        chk("R1 trigger", int'(trg[0]), 0);

        // R9: software start and stop
        wr(0, 2'd0, ctl(1, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        chk("R9 counting after write", int'(cnt[0]) > 0, 1);
        wr(0, 2'd0, ctl(0, 0, 0, 0, 0));
        c1 = int'(cnt[0]);
        repeat (3) @(negedge clk);
        chk("R9 count holds", int'(cnt[0]), c1);
        chk("R9 enable low", int'(cen[0]), 0);

        // R8: prescaler 2 -> one step every 3 clocks
        wr(0, 2'd1, 16'd2);
        c0 = int'(cnt[0]);
        wr(0, 2'd0, ctl(1, 0, 0, 0, 0));
        repeat (8) @(negedge clk);
        chk("R8 two steps", int'(cnt[0]), c0 + 2);
        @(negedge clk);
        chk("R8 third step", int'(cnt[0]), c0 + 3);
        wr(0, 2'd0, ctl(0, 0, 0, 0, 0));
        wr(0, 2'd1, 16'd0);

        // R4, R6, R7: flag without starting
        wr(0, 2'd0, ctl(0, 0, 4, 0, 0));
        pulse();
        chk("R4 channel edge flags", int'(flg[0]), 1);
        chk("R6 no start outside event mode", int'(cen[0]), 0);
        wr(0, 2'd2, 16'd1);
        chk("R7 write one keeps flag", int'(flg[0]), 1);
        wr(0, 2'd2, 16'd0);
        chk("R7 write zero clears", int'(flg[0]), 0);
        wr(0, 2'd0, ctl(0, 0, 0, 0, 0));
        pulse();
        chk("R4 unselected source ignored", int'(flg[0]), 0);

        // R5: event mode start, later triggers keep it running
        wr(0, 2'd0, ctl(0, 0, 4, 6, 0));
        pulse();
        chk("R5 event starts", int'(cen[0]), 1);
        c0 = int'(cnt[0]);
        pulse();
        pulse();
        chk("R5 still enabled", int'(cen[0]), 1);
        chk("R5 still counting", int'(cnt[0]) != c0, 1);
        wr(0, 2'd0, ctl(0, 0, 0, 0, 0));

        // R10 and R2: sync holdoff, enable on trigger output
        c0 = int'(cnt[0]);
        wr(0, 2'd0, ctl(1, 1, 0, 0, 1));
        repeat (2) @(negedge clk);
        chk("R10 held off", int'(cnt[0]), c0);
        chk("R2 trigger follows enable", int'(trg[0]), 1);
        @(negedge clk);
        chk("R10 first step", int'(cnt[0]), c0 + 1);
        wr(0, 2'd0, ctl(0, 0, 0, 0, 1));
        c1 = int'(cnt[0]);
        @(negedge clk);
        chk("R2 trigger low in quiet mode", int'(trg[0]), 0);
        @(negedge clk);
        chk("R10 stops at once", int'(cnt[0]), c1);

        // R11, R3: master/slave lockstep
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wr(0, 2'd1, 16'd1);
        wr(1, 2'd1, 16'd1);
        wr(1, 2'd0, ctl(0, 0, 2, 6, 0));
        wr(0, 2'd0, ctl(0, 1, 4, 6, 1));
        pulse();
        repeat (3) @(negedge clk);
        chk("R3 slave flagged by neighbour", int'(flg[1]), 1);
        chk("R3 slave started", int'(cen[1]), 1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R11 lockstep", int'(cnt[1]), int'(cnt[0]));
        end
        chk("R11 counting", int'(cnt[0]) > 0, 1);

        // R12: wrap
        wr(0, 2'd0, ctl(0, 0, 0, 0, 0));
        wr(0, 2'd1, 16'd0);
        wr(0, 2'd0, ctl(1, 0, 0, 0, 0));
        c0 = int'(cnt[0]);
        repeat (65536 - c0) @(negedge clk);
        chk("R12 wrap to zero", int'(cnt[0]), 0);
        @(negedge clk);
        chk("R12 after wrap", int'(cnt[0]), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule